// File: doc/BRIEF.md
# Interleaved Page Address Generator

This block converts a linear page number into a request for a mesh interconnect. Pages are placed round-robin across a set of memory banks, one page per bank in turn. The bank count does not have to be a power of two, and the default is six. Every bank holds its share of the buffer at one common base address. The request names the target tile by its x and y coordinates and gives a byte address inside that tile. A small table of coordinate registers, written during configuration, tells the block where each bank sits on the mesh.

A page number enters on a valid/ready input that is ready only while the generator is idle. The block then finds the bank and the row inside that bank with a bit-serial divider, which needs one cycle per index bit. The finished request is presented on a valid/ready output. Once out_valid rises, the request stays fixed until out_ready is seen high at a clock edge, and the input stays not ready for that whole time. The base address, page size and allocated page count are captured when the page number is accepted. The error flag goes with the request itself, so a request is always emitted, even for an index past the end of the buffer.

Top module: `page_addr_gen`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and every coordinate table entry reads as x=0, y=0.
- R2: The out_bank field equals the accepted page index modulo BANKS (default 6), so consecutive indices visit banks 0,1,...,BANKS-1 and then wrap to 0.
- R3: The out_addr field equals base_addr + (page_index div BANKS) * page_size, using the same base for every bank.
- R4: The out_len field equals the page_size captured with the index.
- R5: The out_x and out_y fields (6 bits each) equal the table entry for out_bank. A table entry is written by pulsing cfg_we with cfg_bank, cfg_x and cfg_y. A write whose cfg_bank is BANKS or more changes no entry.
- R6: The out_chan output equals bit 30 of out_addr. This bit picks the second memory channel, which starts at an offset of 1 GiB.
- R7: The out_err output is 1 exactly when the page index is not less than total_pages. The request is still produced.
- R8: A page index is taken only when in_valid and in_ready are both high at a clock edge. in_ready is 0 from acceptance until the request is consumed. Any in_valid seen while in_ready is 0 produces no request.
- R9: While out_valid is 1 and out_ready is 0, out_valid and every request field stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coordinate table write strobe |
| cfg_bank | input | BANK_W | Table entry to write |
| cfg_x | input | 6 | X coordinate to store |
| cfg_y | input | 6 | Y coordinate to store |
| base_addr | input | ADDR_W | Common base address shared by all banks |
| page_size | input | SIZE_W | Page size in bytes |
| total_pages | input | IDX_W | Allocated page count |
| in_valid | input | 1 | Page index offered |
| in_ready | output | 1 | Generator idle, index can be taken |
| in_index | input | IDX_W | Linear page index |
| out_valid | output | 1 | Request available |
| out_ready | input | 1 | Consumer takes request |
| out_bank | output | BANK_W | Target bank number |
| out_x | output | 6 | Target tile x coordinate |
| out_y | output | 6 | Target tile y coordinate |
| out_addr | output | ADDR_W | Local byte address in the tile |
| out_len | output | SIZE_W | Transfer length in bytes |
| out_chan | output | 1 | Memory channel select |
| out_err | output | 1 | Index outside the allocation |

## Verification
Some rules are checked by assertions on every cycle. A held request must not change while it waits. The input must never be ready while a request is pending. The divider remainder must always stay below the bank count. Every emitted bank and row must recombine to the accepted index. Other behaviour only the directed scenarios can show. These include the actual bank and address values for given bases and page sizes, and the round-robin wrap. They also include the coordinate lookup after table writes, the channel bit, the out-of-range flag, and the silent dropping of strobes offered while busy.

// File: rtl/page_addr_gen_pkg.sv
package page_addr_gen_pkg;
  localparam int COORD_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } gen_state_t;
endpackage

// File: rtl/bank_coord_table.sv
module bank_coord_table
  import page_addr_gen_pkg::*;
#(
  parameter int BANKS  = 6,
  parameter int BANK_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [COORD_W-1:0] wr_x,
  input  logic [COORD_W-1:0] wr_y,
  input  logic [BANK_W-1:0]  rd_bank,
  output logic [COORD_W-1:0] rd_x,
  output logic [COORD_W-1:0] rd_y
);
  logic [COORD_W-1:0] x_q [BANKS];
  logic [COORD_W-1:0] y_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x_q[b] <= '0;
        y_q[b] <= '0;
      end else if (we && (wr_bank == BANK_W'(b))) begin
        x_q[b] <= wr_x;
        y_q[b] <= wr_y;
      end
    end
  end

  always_comb begin
    rd_x = '0;
    rd_y = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (rd_bank == BANK_W'(b)) begin
        rd_x = x_q[b];
        rd_y = y_q[b];
      end
    end
  end
endmodule

// File: rtl/serial_const_div.sv
module serial_const_div #(
  parameter int DIVISOR = 6,
  parameter int IDX_W   = 16,
  parameter int REM_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] dividend,
  output logic             done,
  output logic [IDX_W-1:0] quotient,
  output logic [REM_W-1:0] remainder
);
  localparam int CNT_W = $clog2(IDX_W + 1);

  logic [IDX_W-1:0] shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REM_W:0]   trial;
  logic             fits;

  assign trial = {remainder, shift_q[IDX_W-1]};
  assign fits  = trial >= (REM_W+1)'(DIVISOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shift_q   <= dividend;
        cnt_q     <= CNT_W'(IDX_W);
        quotient  <= '0;
        remainder <= '0;
      end else if (cnt_q != '0) begin
        shift_q   <= {shift_q[IDX_W-2:0], 1'b0};
        quotient  <= {quotient[IDX_W-2:0], fits};
        remainder <= fits ? REM_W'(trial - (REM_W+1)'(DIVISOR)) : trial[REM_W-1:0];
        cnt_q     <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  // R2
  rem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(remainder) < DIVISOR);
endmodule

// File: rtl/page_addr_gen.sv
module page_addr_gen
  import page_addr_gen_pkg::*;
#(
  parameter int BANKS    = 6,
  parameter int IDX_W    = 16,
  parameter int SIZE_W   = 16,
  parameter int ADDR_W   = 32,
  parameter int CHAN_BIT = 30,
  parameter int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [BANK_W-1:0]  cfg_bank,
  input  logic [COORD_W-1:0] cfg_x,
  input  logic [COORD_W-1:0] cfg_y,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [SIZE_W-1:0]  page_size,
  input  logic [IDX_W-1:0]   total_pages,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDX_W-1:0]   in_index,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BANK_W-1:0]  out_bank,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [SIZE_W-1:0]  out_len,
  output logic               out_chan,
  output logic               out_err
);
  gen_state_t         state_q;
  logic [IDX_W-1:0]   idx_q, pages_q, row_q;
  logic [ADDR_W-1:0]  base_q;
  logic [SIZE_W-1:0]  size_q;
  logic               accept, div_done;
  logic [IDX_W-1:0]   div_q;
  logic [BANK_W-1:0]  div_r;
  logic [ADDR_W-1:0]  offset;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_OUT);
  assign accept    = in_valid && in_ready;
  assign offset    = ADDR_W'(div_q) * ADDR_W'(size_q);
  assign out_len   = size_q;
  assign out_chan  = out_addr[CHAN_BIT];

  serial_const_div #(.DIVISOR(BANKS), .IDX_W(IDX_W), .REM_W(BANK_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept), .dividend(in_index),
    .done(div_done), .quotient(div_q), .remainder(div_r)
  );

  bank_coord_table #(.BANKS(BANKS), .BANK_W(BANK_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_bank(cfg_bank),
    .wr_x(cfg_x), .wr_y(cfg_y), .rd_bank(out_bank), .rd_x(out_x), .rd_y(out_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      pages_q  <= '0;
      row_q    <= '0;
      base_q   <= '0;
      size_q   <= '0;
      out_bank <= '0;
      out_addr <= '0;
      out_err  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          idx_q   <= in_index;
          pages_q <= total_pages;
          base_q  <= base_addr;
          size_q  <= page_size;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          out_bank <= div_r;
          row_q    <= div_q;
          out_addr <= base_q + offset;
          out_err  <= (idx_q >= pages_q);
          state_q  <= ST_OUT;
        end
        ST_OUT: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bank) && $stable(out_addr)
      && $stable(out_len) && $stable(out_err) && $stable(out_x) && $stable(out_y));
  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R2
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_bank) < BANKS);
  // R3
  row_recombine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(row_q) * BANKS + int'(out_bank)) == int'(idx_q));
endmodule

// File: tb/test_page_addr_gen.sv
module test_page_addr_gen;
  localparam int BANKS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic [5:0]  cfg_x = '0, cfg_y = '0;
  logic [31:0] base_addr = '0;
  logic [15:0] page_size = '0, total_pages = '0, in_index = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, out_chan, out_err;
  logic [2:0]  out_bank;
  logic [5:0]  out_x, out_y;
  logic [31:0] out_addr;
  logic [15:0] out_len;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  page_addr_gen i_page_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .base_addr(base_addr), .page_size(page_size),
    .total_pages(total_pages), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .out_valid(out_valid), .out_ready(out_ready),
    .out_bank(out_bank), .out_x(out_x), .out_y(out_y), .out_addr(out_addr),
    .out_len(out_len), .out_chan(out_chan), .out_err(out_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int b, input int x, input int y);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 3'(b); cfg_x = 6'(x); cfg_y = 6'(y);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input int idx);
    @(negedge clk);
    in_valid = 1'b1; in_index = 16'(idx);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    int t = 0;
    while (!out_valid && t < 100) begin @(negedge clk); t++; end
    check("R8 response arrives", out_valid, 1);
  endtask

  task automatic consume();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);
    base_addr = 32'h100; page_size = 16'd64; total_pages = 16'd100;
    issue(4); wait_out();
    check("R1 x reset", out_x, 0);
    check("R1 y reset", out_y, 0);
    consume();
  endtask

  task automatic t_round_robin();
    for (int b = 0; b < BANKS; b++) write_entry(b, 10 + b, 20 + 2 * b);
    write_entry(6, 63, 63);
    base_addr = 32'h0000_1000; page_size = 16'd2048; total_pages = 16'd64;
    for (int i = 0; i < 14; i++) begin
      issue(i); wait_out();
      check("R2 bank", out_bank, i % BANKS);
      check("R3 addr", out_addr, 32'h1000 + (i / BANKS) * 2048);
      check("R4 len", out_len, 2048);
      check("R5 x", out_x, 10 + i % BANKS);
      check("R5 y", out_y, 20 + 2 * (i % BANKS));
      check("R7 in range", out_err, 0);
      consume();
    end
  endtask

  task automatic t_odd_size_large_index();
    base_addr = 32'h0000_0200; page_size = 16'd100; total_pages = 16'hFFFF;
    issue(65535); wait_out();
    check("R2 bank max idx", out_bank, 3);
    check("R3 addr max idx", out_addr, 32'h200 + 10922 * 100);
    check("R7 idx equals total", out_err, 1);
    consume();
  endtask

  task automatic t_channel();
    base_addr = 32'h4000_0000; page_size = 16'd2048; total_pages = 16'd64;
    issue(7); wait_out();
    check("R6 chan high", out_chan, 1);
    check("R3 addr upper", out_addr, 32'h4000_0800);
    consume();
    base_addr = 32'h3FFF_F800;
    issue(6); wait_out();
    check("R6 chan crosses", out_chan, 1);
    consume();
    base_addr = 32'h1000;
    issue(6); wait_out();
    check("R6 chan low", out_chan, 0);
    consume();
  endtask

  task automatic t_error();
    base_addr = 32'h0; page_size = 16'd2048; total_pages = 16'd12;
    issue(11); wait_out();
    check("R7 last page ok", out_err, 0);
    consume();
    issue(12); wait_out();
    check("R7 past end", out_err, 1);
    check("R7 still bank", out_bank, 0);
    consume();
  endtask

  task automatic t_backpressure();
    total_pages = 16'd64;
    issue(5); wait_out();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9 held valid", out_valid, 1);
      check("R9 held bank", out_bank, 5);
      check("R8 not ready", in_ready, 0);
    end
    consume();
    check("R8 ready again", in_ready, 1);
  endtask

  task automatic t_busy_ignore();
    base_addr = 32'h0; page_size = 16'd16;
    issue(3);
    in_valid = 1'b1; in_index = 16'd40;
    for (int k = 0; k < 3; k++) @(negedge clk);
    in_valid = 1'b0;
    wait_out();
    check("R8 accepted index bank", out_bank, 3);
    check("R8 accepted index addr", out_addr, 0);
    consume();
    for (int k = 0; k < 30; k++) @(negedge clk);
    check("R8 no extra request", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_odd_size_large_index();
    t_channel();
    t_error();
    t_backpressure();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule